// File: doc/BRIEF.md
# Four-Source Event Interrupt Hub

The hub collects events from two mezzanine slots, a trigger and an end-of-acquisition strobe from each. It catches them in per-source pending bits and combines them into one interrupt request for the host. Each source passes through a configurable synchroniser. A rising edge on an enabled source marks it pending. Software works through a 32-bit Wishbone slave with four word registers.

Enables are never written directly. One register sets enable bits for every 1 written to it, and a second register clears enable bits in the same way. A read-only view returns the current enable mask. A status register shows what is pending and clears the bits that are written with 1. The interrupt output is one register stage after the pending and enable state.

Top module: `irq_hub`

## Requirements
- R1: After reset every enable bit, every pending bit, `irq_o` and `wb_ack_o` are 0.
- R2: Byte address bits [3:2] select the register: 0 clears enables, 1 sets enables, 2 reads the enable mask, 3 holds the pending status. Bits [1:0] are ignored. In all four registers, bit 0 is the slot-1 trigger, bit 1 the slot-1 end of acquisition, bit 2 the slot-2 trigger and bit 3 the slot-2 end of acquisition.
- R3: Each 1 written to the enable-clear register (offset 0x0) turns that source's enable off. Bits written 0 keep their enable.
- R4: Each 1 written to the enable-set register (offset 0x4) turns that source's enable on. Bits written 0 keep their enable.
- R5: Writes to the mask view (offset 0x8) change nothing. Reads of offsets 0x0 and 0x4, reads of any address with a bit set above bit 3, and all data bits above the source count return 0. Writes to such addresses change nothing.
- R6: A 0-to-1 transition on a source, after `SYNC_STAGES` synchroniser flops, sets its pending bit only if that source is enabled. A source that stays high does not set the bit again.
- R7: Each 1 written to the status register (offset 0xC) clears that pending bit, and bits written 0 keep their state. When a new event and a clear hit the same bit in the same cycle, the bit stays pending.
- R8: `irq_o` is high one cycle after any source is both pending and enabled. Disabling a source keeps its pending bit but removes that bit from `irq_o`.
- R9: `wb_ack_o` rises on the clock edge after `wb_cyc_i` and `wb_stb_i` are seen high. It stays high for one cycle per access. Write effects and read data are taken at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wb_cyc_i | input | 1 | Bus cycle in progress |
| wb_stb_i | input | 1 | Strobe for this slave |
| wb_we_i | input | 1 | 1 for a write, 0 for a read |
| wb_adr_i | input | ADDR_W (6) | Byte address |
| wb_dat_i | input | DATA_W (32) | Write data |
| wb_dat_o | output | DATA_W (32) | Read data, valid while ack is high |
| wb_ack_o | output | 1 | Access acknowledge |
| src_i | input | N_SRC (4) | Event sources, bit order as in R2 |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions assume a host that drops `wb_stb_i` after each acknowledge, so that every access is a single beat. They also assume that only one register is addressed per access, so that enable-set and enable-clear strobes never occur in the same cycle. The bench tasks raise the strobe at a falling edge and release it at the falling edge after the acknowledge, which keeps every access single-beat. Source inputs change only at falling edges. The event-versus-clear collision is timed by counting synchroniser stages, so that the synchronised edge reaches the pending logic on the same edge as the status write.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

   // Register select, taken from byte address bits [3:2]
   typedef enum logic [1:0] {
      HUB_EN_CLR = 2'd0,
      HUB_EN_SET = 2'd1,
      HUB_EN_VIEW = 2'd2,
      HUB_PEND = 2'd3
   } hub_reg_e;

   localparam int unsigned HUB_SEL_LSB = 2;
   localparam int unsigned HUB_SEL_W = 2;

endpackage

// File: rtl/irq_hub_sync.sv
module irq_hub_sync #(
   parameter int unsigned N_SRC = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [N_SRC-1:0] src_i,
   output logic [N_SRC-1:0] rise_o
);

   logic [N_SRC-1:0] s_lvl;
   logic [N_SRC-1:0] s_prev;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign s_lvl = src_i;
      end else begin : g_chain
         logic [N_SRC-1:0] stg [SYNC_STAGES];
         always_ff @(posedge clk) begin
            if (rst) begin
               for (int k = 0; k < SYNC_STAGES; k++) stg[k] <= '0;
            end else begin
               stg[0] <= src_i;
               for (int k = 1; k < SYNC_STAGES; k++) stg[k] <= stg[k-1];
            end
         end
         assign s_lvl = stg[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) s_prev <= '0;
      else     s_prev <= s_lvl;
   end

   assign rise_o = s_lvl & ~s_prev;

   // R6: an edge pulse lasts a single cycle
   a_r6_rise_single: assert property (@(posedge clk) disable iff (rst)
      (rise_o & $past(rise_o)) == '0);

endmodule

// File: rtl/irq_hub_core.sv
module irq_hub_core #(
   parameter int unsigned N_SRC = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [N_SRC-1:0] rise_i,
   input  logic [N_SRC-1:0] en_set_i,
   input  logic [N_SRC-1:0] en_clr_i,
   input  logic [N_SRC-1:0] pend_clr_i,
   output logic [N_SRC-1:0] en_q,
   output logic [N_SRC-1:0] pend_q,
   output logic             irq_q
);

   logic [N_SRC-1:0] hit;

   assign hit = rise_i & en_q;

   generate
      for (genvar i = 0; i < N_SRC; i++) begin : g_bit
         always_ff @(posedge clk) begin
            if (rst) begin
               en_q[i]   <= 1'b0;
               pend_q[i] <= 1'b0;
            end else begin
               if (en_set_i[i])      en_q[i] <= 1'b1;
               else if (en_clr_i[i]) en_q[i] <= 1'b0;
               // a fresh event outranks a clear in the same cycle
               if (hit[i])             pend_q[i] <= 1'b1;
               else if (pend_clr_i[i]) pend_q[i] <= 1'b0;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) irq_q <= 1'b0;
      else     irq_q <= |(pend_q & en_q);
   end

   a_r4_enable_set: assert property (@(posedge clk) disable iff (rst)
      (|en_set_i) |=> ((en_q & $past(en_set_i)) == $past(en_set_i)));

   a_r3_enable_clear: assert property (@(posedge clk) disable iff (rst)
      (|en_clr_i) |=> ((en_q & $past(en_clr_i)) == '0));

   a_r7_event_wins: assert property (@(posedge clk) disable iff (rst)
      (|hit) |=> ((pend_q & $past(hit)) == $past(hit)));

   a_r6_pend_needs_enable: assert property (@(posedge clk) disable iff (rst)
      ((pend_q & ~$past(pend_q)) & ~$past(rise_i & en_q)) == '0);

endmodule

// File: rtl/irq_hub_wb.sv
module irq_hub_wb
   import irq_hub_pkg::*;
#(
   parameter int unsigned N_SRC = 4,
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wb_cyc_i,
   input  logic              wb_stb_i,
   input  logic              wb_we_i,
   input  logic [ADDR_W-1:0] wb_adr_i,
   input  logic [DATA_W-1:0] wb_dat_i,
   output logic [DATA_W-1:0] wb_dat_o,
   output logic              wb_ack_o,
   input  logic [N_SRC-1:0]  en_i,
   input  logic [N_SRC-1:0]  pend_i,
   output logic [N_SRC-1:0]  en_set_o,
   output logic [N_SRC-1:0]  en_clr_o,
   output logic [N_SRC-1:0]  pend_clr_o
);

   localparam int unsigned HI_LSB = HUB_SEL_LSB + HUB_SEL_W;

   logic       take;
   logic       in_map;
   hub_reg_e   sel;
   logic [N_SRC-1:0] wmask;
   logic [N_SRC-1:0] rd_bits;

   assign take = wb_cyc_i & wb_stb_i & ~wb_ack_o;
   assign sel  = hub_reg_e'(wb_adr_i[HUB_SEL_LSB +: HUB_SEL_W]);

   generate
      if (ADDR_W > HI_LSB) begin : g_hi
         assign in_map = (wb_adr_i[ADDR_W-1:HI_LSB] == '0);
      end else begin : g_nohi
         assign in_map = 1'b1;
      end
      if (DATA_W > N_SRC) begin : g_wide
         logic unused_hi;
         assign unused_hi = ^wb_dat_i[DATA_W-1:N_SRC];
      end
   endgenerate

   logic unused_lo;
   assign unused_lo = ^wb_adr_i[HUB_SEL_LSB-1:0];

   assign wmask = (take & wb_we_i & in_map) ? wb_dat_i[N_SRC-1:0] : '0;

   assign en_clr_o   = (sel == HUB_EN_CLR) ? wmask : '0;
   assign en_set_o   = (sel == HUB_EN_SET) ? wmask : '0;
   assign pend_clr_o = (sel == HUB_PEND)   ? wmask : '0;

   always_comb begin
      rd_bits = '0;
      if (in_map) begin
         unique case (sel)
            HUB_EN_VIEW: rd_bits = en_i;
            HUB_PEND:    rd_bits = pend_i;
            default:     rd_bits = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wb_ack_o <= 1'b0;
         wb_dat_o <= '0;
      end else begin
         wb_ack_o <= take;
         wb_dat_o <= (take & ~wb_we_i) ? DATA_W'(rd_bits) : '0;
      end
   end

   a_r9_ack_single: assert property (@(posedge clk) disable iff (rst)
      wb_ack_o |=> !wb_ack_o);

   a_r9_ack_follows_req: assert property (@(posedge clk) disable iff (rst)
      wb_ack_o |-> $past(wb_cyc_i && wb_stb_i));

   a_r5_one_target: assert property (@(posedge clk) disable iff (rst)
      $onehot0({|en_clr_o, |en_set_o, |pend_clr_o}));

endmodule

// File: rtl/irq_hub.sv
module irq_hub #(
   parameter int unsigned N_SRC = 4,
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wb_cyc_i,
   input  logic              wb_stb_i,
   input  logic              wb_we_i,
   input  logic [ADDR_W-1:0] wb_adr_i,
   input  logic [DATA_W-1:0] wb_dat_i,
   output logic [DATA_W-1:0] wb_dat_o,
   output logic              wb_ack_o,
   input  logic [N_SRC-1:0]  src_i,
   output logic              irq_o
);

   generate
      if (N_SRC < 1 || N_SRC > DATA_W) begin : g_bad_n
         $error("irq_hub: N_SRC must be 1..DATA_W");
      end
      if (ADDR_W < 4) begin : g_bad_a
         $error("irq_hub: ADDR_W must cover four word registers");
      end
      if (SYNC_STAGES > 4) begin : g_bad_s
         $error("irq_hub: SYNC_STAGES above 4 is not supported");
      end
   endgenerate

   logic [N_SRC-1:0] rise;
   logic [N_SRC-1:0] en_q, pend_q;
   logic [N_SRC-1:0] en_set, en_clr, pend_clr;

   irq_hub_sync #(.N_SRC(N_SRC), .SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .src_i(src_i), .rise_o(rise)
   );

   irq_hub_wb #(.N_SRC(N_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wb (
      .clk(clk), .rst(rst),
      .wb_cyc_i(wb_cyc_i), .wb_stb_i(wb_stb_i), .wb_we_i(wb_we_i),
      .wb_adr_i(wb_adr_i), .wb_dat_i(wb_dat_i),
      .wb_dat_o(wb_dat_o), .wb_ack_o(wb_ack_o),
      .en_i(en_q), .pend_i(pend_q),
      .en_set_o(en_set), .en_clr_o(en_clr), .pend_clr_o(pend_clr)
   );

   irq_hub_core #(.N_SRC(N_SRC)) u_core (
      .clk(clk), .rst(rst), .rise_i(rise),
      .en_set_i(en_set), .en_clr_i(en_clr), .pend_clr_i(pend_clr),
      .en_q(en_q), .pend_q(pend_q), .irq_q(irq_o)
   );

   // R1: a cycle spent in reset leaves the request low
   a_r1_irq_reset: assert property (@(posedge clk) $past(rst) |-> !irq_o);

endmodule

// File: tb/irq_hub_tb.sv
module irq_hub_tb;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
   logic [5:0]  adr = '0;
   logic [31:0] wdat = '0;
   logic [31:0] rdat;
   logic        ack;
   logic [3:0]  src = '0;
   logic        irq;

   int n_vec = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   irq_hub u_dut (
      .clk(clk), .rst(rst),
      .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
      .wb_adr_i(adr), .wb_dat_i(wdat),
      .wb_dat_o(rdat), .wb_ack_o(ack),
      .src_i(src), .irq_o(irq)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      cyc = 1; stb = 1; we = 1; adr = a; wdat = d;
      @(negedge clk);
      cyc = 0; stb = 0; we = 0; wdat = '0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      cyc = 1; stb = 1; we = 0; adr = a;
      @(negedge clk);
      d = rdat;
      cyc = 0; stb = 0;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic pulse(input logic [3:0] m);
      @(negedge clk); src = src | m;
      @(negedge clk); src = src & ~m;
      idle(5);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      chk("R1 ack", {31'd0, ack}, 32'd0);
      chk("R1 irq", {31'd0, irq}, 32'd0);
      rd(6'h08, d); chk("R1 mask", d, 32'd0);
      rd(6'h0C, d); chk("R1 status", d, 32'd0);
   endtask

   task automatic t_ack();
      @(negedge clk);
      cyc = 1; stb = 1; we = 0; adr = 6'h08;
      #1 chk("R9 no ack before edge", {31'd0, ack}, 32'd0);
      @(negedge clk);
      chk("R9 ack after edge", {31'd0, ack}, 32'd1);
      @(negedge clk);
      chk("R9 ack single cycle", {31'd0, ack}, 32'd0);
      cyc = 0; stb = 0;
      @(negedge clk);
      chk("R9 ack idle", {31'd0, ack}, 32'd0);
   endtask

   task automatic t_enable();
      logic [31:0] d;
      wr(6'h04, 32'h5); rd(6'h08, d); chk("R4 set 0101", d, 32'h5);
      wr(6'h04, 32'h2); rd(6'h08, d); chk("R4 zeros keep", d, 32'h7);
      wr(6'h00, 32'h1); rd(6'h08, d); chk("R3 clear bit0", d, 32'h6);
      wr(6'h00, 32'h0); rd(6'h08, d); chk("R3 zeros keep", d, 32'h6);
   endtask

   task automatic t_readonly();
      logic [31:0] d;
      wr(6'h08, 32'hF); rd(6'h08, d); chk("R5 mask write ignored", d, 32'h6);
      rd(6'h00, d); chk("R5 clear reg reads 0", d, 32'h0);
      rd(6'h04, d); chk("R5 set reg reads 0", d, 32'h0);
      rd(6'h18, d); chk("R5 high address reads 0", d, 32'h0);
      wr(6'h14, 32'h9); rd(6'h08, d); chk("R5 high address write ignored", d, 32'h6);
      rd(6'h0B, d); chk("R2 low address bits ignored", d, 32'h6);
   endtask

   task automatic t_events();
      logic [31:0] d;
      pulse(4'b0011);
      rd(6'h0C, d); chk("R6 only enabled source", d, 32'h2);
      chk("R8 irq raised", {31'd0, irq}, 32'd1);
      @(negedge clk); src[2] = 1'b1; idle(5);
      rd(6'h0C, d); chk("R6 slot2 trigger edge", d, 32'h6);
      wr(6'h0C, 32'h4); idle(4);
      rd(6'h0C, d); chk("R7 clear; R6 held level no retrigger", d, 32'h2);
      wr(6'h0C, 32'h0);
      rd(6'h0C, d); chk("R7 zeros keep", d, 32'h2);
      wr(6'h00, 32'h2); idle(2);
      rd(6'h0C, d); chk("R8 disable keeps pending", d, 32'h2);
      chk("R8 irq drops when disabled", {31'd0, irq}, 32'd0);
      wr(6'h04, 32'h2); idle(2);
      chk("R8 irq back on enable", {31'd0, irq}, 32'd1);
      wr(6'h0C, 32'hF); idle(2);
      rd(6'h0C, d); chk("R7 clear all", d, 32'h0);
      chk("R8 irq low with nothing pending", {31'd0, irq}, 32'd0);
      @(negedge clk); src[2] = 1'b0; idle(4);
   endtask

   task automatic t_collide();
      logic [31:0] d;
      wr(6'h04, 32'h8);
      pulse(4'b1000);
      rd(6'h0C, d); chk("R2 bit3 slot2 acq end", d, 32'h8);
      wr(6'h0C, 32'h8);
      rd(6'h0C, d); chk("R7 cleared before collision", d, 32'h0);
      // source edge reaches pending logic on the third rising edge
      @(negedge clk); src[3] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      cyc = 1; stb = 1; we = 1; adr = 6'h0C; wdat = 32'h8;
      @(negedge clk);
      cyc = 0; stb = 0; we = 0; wdat = '0;
      src[3] = 1'b0;
      rd(6'h0C, d); chk("R7 event wins over clear", d, 32'h8);
   endtask

   initial begin
      idle(3);
      rst = 0;
      t_reset();
      t_ack();
      t_enable();
      t_readonly();
      t_events();
      t_collide();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_vec++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule